// File: doc/BRIEF.md
# Scan Shift Toggle Monitor

The block observes a parallel snapshot of every scan cell. On each shift clock it counts how many cells changed value since the previous counted vector. It then tests that count against a programmable percentage of the cell count and raises a violation for any shift clock that goes over the limit. The single capture clock that follows loading has its own percentage limit.

A start strobe opens a pattern and an end strobe closes it. For each pattern the block keeps the following: a sticky violation bit, the shift index of the first violation, the largest single-shift count, the total of all shift toggles and the number of counted shifts. The average toggle rate per shift is the total divided by the shift count. This division is done outside the block.

Top module: `scan_toggle_monitor`

## Requirements
- R1: The toggle count of a counted cycle is the number of bits in which `cells_i` differs from the vector sampled on the most recent cycle that had `shift_en_i` or `capture_i` high. That reference vector is 0 after reset. Cycles with both `shift_en_i` and `capture_i` low neither count toggles nor update the reference.
- R2: The effective limit percentage is computed from the percentage input. A value of 0 selects the default: 15 for shift and 20 for capture. Any other value is clamped to the range 10 to 25. A count is over the limit when count×100 > pct×N_CELLS.
- R3: `viol_o` is high for exactly the one cycle after a counted cycle whose count was over its limit. Otherwise it is low.
- R4: `sticky_o` sets on the first over-limit shift of a pattern and stays set until the next start. `first_idx_o` holds the 0-based shift index of that shift and does not change for later violations.
- R5: `max_cnt_o` holds the largest toggle count of any counted shift in the current pattern.
- R6: `total_o` accumulates the shift toggle counts and saturates at all ones. `shift_cnt_o` counts the counted shifts and also saturates.
- R7: A capture cycle is tested against the capture limit and sets the sticky `cap_viol_o`. It leaves max, total and shift count unchanged. When `shift_en_i` and `capture_i` are both high, the cycle is treated as a shift.
- R8: `pat_start_i` clears all statistics and opens the pattern, and the start cycle itself is not counted. `pat_end_i` closes the pattern after that cycle has been counted. Shifts outside an open pattern leave every statistic and `viol_o` unchanged.
- R9: After reset all outputs are 0.
- R10: The first shift after a start is compared against the reference held from before the pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cells_i | input | N_CELLS | Scan cell snapshot |
| shift_en_i | input | 1 | Shift clock qualifier |
| capture_i | input | 1 | Capture clock qualifier |
| pat_start_i | input | 1 | Pattern start strobe |
| pat_end_i | input | 1 | Pattern end strobe |
| shift_pct_i | input | PCT_W | Shift limit in percent (0 = default) |
| cap_pct_i | input | PCT_W | Capture limit in percent (0 = default) |
| viol_o | output | 1 | Violation on the previous counted cycle |
| sticky_o | output | 1 | Sticky shift violation |
| cap_viol_o | output | 1 | Sticky capture violation |
| first_idx_o | output | IDX_W | Shift index of the first shift violation |
| max_cnt_o | output | CNT_W | Largest single-shift toggle count |
| total_o | output | TOT_W | Saturating toggle total |
| shift_cnt_o | output | IDX_W | Saturating count of counted shifts |

## Verification
The hardest state to reach is a saturated total. With the default sizes it needs more than 4095 toggles inside a single pattern. The stimulus reaches it with 70 consecutive shifts that invert every cell, and then checks the clamped total and the shift count. The stimulus also changes the cells during idle cycles to show that the reference vector holds its value. It drives one cycle with shift and capture together, at a toggle count that only the capture limit would reject.

// File: rtl/scan_tmon_pkg.sv
package scan_tmon_pkg;
  // Effective limit: 0 picks the default, otherwise clamp to [lo, hi].
  function automatic int eff_pct(input int pct, input int def, input int lo, input int hi);
    if (pct == 0) return def;
    if (pct < lo) return lo;
    if (pct > hi) return hi;
    return pct;
  endfunction
endpackage

// File: rtl/stm_toggle_count.sv
module stm_toggle_count #(
  parameter int N_CELLS = 64,
  parameter int CNT_W   = $clog2(N_CELLS + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_CELLS-1:0] cells_i,
  input  logic               en_i,
  output logic [CNT_W-1:0]   cnt_o
);
  logic [N_CELLS-1:0] ref_q;
  logic [N_CELLS-1:0] diff;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ref_q <= '0;
    else if (en_i) ref_q <= cells_i;
  end

  assign diff = cells_i ^ ref_q;

  always_comb begin
    cnt_o = '0;
    for (int i = 0; i < N_CELLS; i++) cnt_o = cnt_o + CNT_W'(diff[i]);
  end
endmodule

// File: rtl/stm_limit_cmp.sv
module stm_limit_cmp #(
  parameter int N_CELLS = 64,
  parameter int CNT_W   = $clog2(N_CELLS + 1),
  parameter int PCT_W   = 7,
  parameter int DEF_PCT = 15,
  parameter int MIN_PCT = 10,
  parameter int MAX_PCT = 25
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [PCT_W-1:0] pct_i,
  output logic             over_o
);
  localparam int PRD_W = CNT_W + PCT_W + $clog2(N_CELLS + 1) + 1;

  int               eff;
  logic [PRD_W-1:0] lhs;
  logic [PRD_W-1:0] rhs;

  always_comb begin
    eff    = scan_tmon_pkg::eff_pct(int'(pct_i), DEF_PCT, MIN_PCT, MAX_PCT);
    lhs    = PRD_W'(cnt_i) * PRD_W'(100);
    rhs    = PRD_W'(eff) * PRD_W'(N_CELLS);
    over_o = lhs > rhs;
  end
endmodule

// File: rtl/stm_stats.sv
module stm_stats #(
  parameter int CNT_W = 7,
  parameter int TOT_W = 12,
  parameter int IDX_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             end_i,
  input  logic             shift_i,
  input  logic             cap_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             sh_over_i,
  input  logic             cap_over_i,
  output logic             viol_o,
  output logic             sticky_o,
  output logic             cap_viol_o,
  output logic [IDX_W-1:0] first_idx_o,
  output logic [CNT_W-1:0] max_o,
  output logic [TOT_W-1:0] total_o,
  output logic [IDX_W-1:0] scnt_o
);
  logic           active_q;
  logic [TOT_W:0] sum;

  assign sum = {1'b0, total_o} + (TOT_W + 1)'(cnt_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q    <= 1'b0;
      viol_o      <= 1'b0;
      sticky_o    <= 1'b0;
      cap_viol_o  <= 1'b0;
      first_idx_o <= '0;
      max_o       <= '0;
      total_o     <= '0;
      scnt_o      <= '0;
    end else if (start_i) begin
      active_q    <= 1'b1;
      viol_o      <= 1'b0;
      sticky_o    <= 1'b0;
      cap_viol_o  <= 1'b0;
      first_idx_o <= '0;
      max_o       <= '0;
      total_o     <= '0;
      scnt_o      <= '0;
    end else begin
      viol_o <= 1'b0;
      if (active_q && shift_i) begin
        viol_o <= sh_over_i;
        if (sh_over_i && !sticky_o) begin
          sticky_o    <= 1'b1;
          first_idx_o <= scnt_o;
        end
        if (cnt_i > max_o) max_o <= cnt_i;
        total_o <= sum[TOT_W] ? '1 : sum[TOT_W-1:0];
        if (scnt_o != '1) scnt_o <= scnt_o + 1'b1;
      end else if (active_q && cap_i) begin
        viol_o <= cap_over_i;
        if (cap_over_i) cap_viol_o <= 1'b1;
      end
      if (end_i) active_q <= 1'b0;
    end
  end
endmodule

// File: rtl/scan_toggle_monitor.sv
module scan_toggle_monitor #(
  parameter int N_CELLS   = 64,
  parameter int PCT_W     = 7,
  parameter int SHIFT_DEF = 15,
  parameter int CAP_DEF   = 20,
  parameter int MIN_PCT   = 10,
  parameter int MAX_PCT   = 25,
  parameter int TOT_W     = 12,
  parameter int IDX_W     = 8,
  localparam int CNT_W    = $clog2(N_CELLS + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_CELLS-1:0] cells_i,
  input  logic               shift_en_i,
  input  logic               capture_i,
  input  logic               pat_start_i,
  input  logic               pat_end_i,
  input  logic [PCT_W-1:0]   shift_pct_i,
  input  logic [PCT_W-1:0]   cap_pct_i,
  output logic               viol_o,
  output logic               sticky_o,
  output logic               cap_viol_o,
  output logic [IDX_W-1:0]   first_idx_o,
  output logic [CNT_W-1:0]   max_cnt_o,
  output logic [TOT_W-1:0]   total_o,
  output logic [IDX_W-1:0]   shift_cnt_o
);
  logic [CNT_W-1:0] cnt;
  logic [1:0]       over;
  logic [PCT_W-1:0] pct_sel [2];

  assign pct_sel[0] = shift_pct_i;
  assign pct_sel[1] = cap_pct_i;

  stm_toggle_count #(.N_CELLS(N_CELLS), .CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cells_i(cells_i),
    .en_i   (shift_en_i | capture_i),
    .cnt_o  (cnt)
  );

  // One comparator per limit kind: 0 = shift, 1 = capture.
  for (genvar g = 0; g < 2; g++) begin : g_lim
    stm_limit_cmp #(
      .N_CELLS(N_CELLS), .CNT_W(CNT_W), .PCT_W(PCT_W),
      .DEF_PCT(g == 0 ? SHIFT_DEF : CAP_DEF),
      .MIN_PCT(MIN_PCT), .MAX_PCT(MAX_PCT)
    ) u_cmp (
      .cnt_i (cnt),
      .pct_i (pct_sel[g]),
      .over_o(over[g])
    );
  end

  stm_stats #(.CNT_W(CNT_W), .TOT_W(TOT_W), .IDX_W(IDX_W)) u_stats (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (pat_start_i),
    .end_i      (pat_end_i),
    .shift_i    (shift_en_i),
    .cap_i      (capture_i),
    .cnt_i      (cnt),
    .sh_over_i  (over[0]),
    .cap_over_i (over[1]),
    .viol_o     (viol_o),
    .sticky_o   (sticky_o),
    .cap_viol_o (cap_viol_o),
    .first_idx_o(first_idx_o),
    .max_o      (max_cnt_o),
    .total_o    (total_o),
    .scnt_o     (shift_cnt_o)
  );
endmodule

// File: rtl/stm_checker.sv
module stm_checker #(
  parameter int CNT_W = 7,
  parameter int TOT_W = 12,
  parameter int IDX_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             pat_start_i,
  input logic             viol_o,
  input logic             sticky_o,
  input logic             cap_viol_o,
  input logic [IDX_W-1:0] first_idx_o,
  input logic [CNT_W-1:0] max_cnt_o,
  input logic [TOT_W-1:0] total_o,
  input logic [IDX_W-1:0] shift_cnt_o
);
  assert_max_monotonic_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pat_start_i |=> max_cnt_o >= $past(max_cnt_o));

  assert_total_monotonic_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pat_start_i |=> total_o >= $past(total_o) && shift_cnt_o >= $past(shift_cnt_o));

  assert_start_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pat_start_i |=> total_o == '0 && max_cnt_o == '0 && shift_cnt_o == '0
                    && !sticky_o && !cap_viol_o && !viol_o);

  assert_sticky_holds_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sticky_o && !pat_start_i |=> sticky_o && $stable(first_idx_o));

  assert_viol_marks_sticky_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_o |-> sticky_o || cap_viol_o);

  assert_cap_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_viol_o && !pat_start_i |=> cap_viol_o);
endmodule

bind scan_toggle_monitor stm_checker #(.CNT_W(CNT_W), .TOT_W(TOT_W), .IDX_W(IDX_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .pat_start_i(pat_start_i),
  .viol_o     (viol_o),
  .sticky_o   (sticky_o),
  .cap_viol_o (cap_viol_o),
  .first_idx_o(first_idx_o),
  .max_cnt_o  (max_cnt_o),
  .total_o    (total_o),
  .shift_cnt_o(shift_cnt_o)
);

// File: tb/sim_scan_toggle_monitor.sv
`timescale 1ns/1ps
module sim_scan_toggle_monitor;
  localparam int N = 64;
  localparam int CW = 7;
  localparam int TW = 12;
  localparam int IW = 8;

  typedef struct {
    string         tag;
    logic          viol, sticky, capv;
    logic [IW-1:0] first, scnt;
    logic [CW-1:0] mx;
    logic [TW-1:0] tot;
  } exp_t;

  logic clk = 0, rst_n = 0;
  logic [N-1:0] cells = '0;
  logic sh = 0, cap = 0, st = 0, en = 0;
  logic [6:0] sp = 0, cp = 0;
  logic viol, sticky, capv;
  logic [IW-1:0] first, scnt;
  logic [CW-1:0] mx;
  logic [TW-1:0] tot;

  int checks = 0, errors = 0;
  exp_t q[$];

  // reference model state
  logic [N-1:0] m_ref = '0, cur = '0;
  logic m_act = 0, m_viol = 0, m_sticky = 0, m_capv = 0;
  logic [IW-1:0] m_first = 0, m_scnt = 0;
  logic [CW-1:0] m_max = 0;
  int m_tot = 0;

  always #5 clk = ~clk;

  scan_toggle_monitor u0 (
    .clk_i(clk), .rst_ni(rst_n), .cells_i(cells), .shift_en_i(sh), .capture_i(cap),
    .pat_start_i(st), .pat_end_i(en), .shift_pct_i(sp), .cap_pct_i(cp),
    .viol_o(viol), .sticky_o(sticky), .cap_viol_o(capv), .first_idx_o(first),
    .max_cnt_o(mx), .total_o(tot), .shift_cnt_o(scnt)
  );

  function automatic int eff(input int p, input int d);
    if (p == 0) return d;
    if (p < 10) return 10;
    if (p > 25) return 25;
    return p;
  endfunction

  task automatic chk(input string what, input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s [%s]: actual %0d expected %0d", what, tag, act, exp);
    end
  endtask

  task automatic step(input logic [N-1:0] c, input logic s, input logic k,
                      input logic start, input logic stop, input string tag);
    exp_t e;
    int n;
    @(negedge clk);
    cells = c; sh = s; cap = k; st = start; en = stop; cur = c;
    n = $countones(c ^ m_ref);
    if (start) begin
      m_act = 1; m_viol = 0; m_sticky = 0; m_capv = 0;
      m_first = 0; m_max = 0; m_tot = 0; m_scnt = 0;
    end else begin
      m_viol = 0;
      if (m_act && s) begin
        m_viol = n * 100 > eff(int'(sp), 15) * N;
        if (m_viol && !m_sticky) begin m_sticky = 1; m_first = m_scnt; end
        if (n > int'(m_max)) m_max = CW'(n);
        m_tot = (m_tot + n > 4095) ? 4095 : m_tot + n;
        if (m_scnt != 8'hFF) m_scnt++;
      end else if (m_act && k) begin
        m_viol = n * 100 > eff(int'(cp), 20) * N;
        if (m_viol) m_capv = 1;
      end
      if (stop) m_act = 0;
    end
    if (s || k) m_ref = c;
    e.tag = tag; e.viol = m_viol; e.sticky = m_sticky; e.capv = m_capv;
    e.first = m_first; e.scnt = m_scnt; e.mx = m_max; e.tot = TW'(m_tot);
    q.push_back(e);
    @(posedge clk); #1;
  endtask

  function automatic logic [N-1:0] msk(input int k);
    return (k >= N) ? '1 : ((64'd1 << k) - 64'd1);
  endfunction

  task automatic tog(input int k, input string tag);
    step(cur ^ msk(k), 1, 0, 0, 0, tag);
  endtask

  task automatic idle(input logic [N-1:0] c, input string tag);
    step(c, 0, 0, 0, 0, tag);
  endtask

  // monitor: pops one expected item per edge
  initial forever begin
    @(posedge clk); #2;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk("viol R3", e.tag, viol, e.viol);
      chk("sticky R4", e.tag, sticky, e.sticky);
      chk("first_idx R4", e.tag, first, e.first);
      chk("cap_viol R7", e.tag, capv, e.capv);
      chk("max R5", e.tag, mx, e.mx);
      chk("total R6", e.tag, tot, e.tot);
      chk("shift_cnt R6", e.tag, scnt, e.scnt);
    end
  end

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("reset viol R9", "R9", viol, 0);
    chk("reset total R9", "R9", tot, 0);
    chk("reset max R9", "R9", mx, 0);
    chk("reset sticky R9", "R9", sticky, 0);
    @(negedge clk); rst_n = 1;
    @(posedge clk); #1;

    // default 15%: limit 9 ok, 10 over
    step(cur, 0, 0, 1, 0, "R8 start");
    tog(9, "R2 default ok");
    tog(10, "R2 default over");
    tog(3, "R1 small");
    tog(12, "R4 second viol");
    idle(64'hDEAD_BEEF_0000_1234, "R1 idle change");
    step(cur ^ 64'h0F, 1, 0, 0, 0, "R1 ref held");
    // capture default 20%: 12 ok, 13 over
    step(cur ^ msk(12), 0, 1, 0, 0, "R7 cap ok");
    step(cur ^ msk(13), 0, 1, 0, 0, "R7 cap over");
    step(cur ^ msk(2), 1, 0, 0, 1, "R8 end counted");
    tog(20, "R8 frozen");
    tog(1, "R8 frozen2");

    // first shift of a pattern against held reference
    idle(64'h0, "R10 idle");
    step(cur, 0, 0, 1, 0, "R8 start2");
    step(cur ^ msk(5), 1, 0, 0, 0, "R10 first shift");
    sp = 5;   // clamps to 10: 6 ok, 7 over
    tog(6, "R2 clamp low ok");
    tog(7, "R2 clamp low over");

    sp = 25;
    step(cur, 0, 0, 1, 0, "R8 start3");
    tog(16, "R2 pct25 ok");
    tog(17, "R2 pct25 over");
    sp = 40;  // clamps to 25
    tog(16, "R2 clamp high ok");
    tog(17, "R2 clamp high over");
    step(cur ^ msk(14), 1, 1, 0, 0, "R7 shift priority");

    // saturation
    step(cur, 0, 0, 1, 0, "R8 start4");
    for (int i = 0; i < 70; i++) tog(64, "R6 saturate");
    idle(cur, "R6 after");
    idle(cur, "R3 drain");
    repeat (3) @(posedge clk);
    #3;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule